// File: doc/BRIEF.md
# Effective Address Generator

This unit computes the 16-bit target address for the addressing modes of an 8-bit processor. On a cycle where `req_valid` is high it takes a mode code, the one or two operand bytes that follow the opcode, the X, Y and stack pointer values, a two-byte pointer already fetched from memory, and the program counter. One clock later it presents the effective address, a flag that tells the sequencer to spend an extra cycle because indexing moved into another page, and the addresses of the two pointer bytes that indirect modes must read.

Zero-page results stay inside page 0 and stack results stay inside page 1. Both zero-page indirect forms are handled: index before the pointer fetch and index after it. Plain zero-page indirect, absolute indirect and X-indexed absolute indirect for jumps are also handled. The sequencer uses `ptr_addr` and `ptr_addr_nxt` to read the pointer, then presents the bytes on `ptr_lo` and `ptr_hi` together with the same mode on a later request.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `out_valid`, `ea`, `page_cross`, `ptr_need`, `ptr_addr` and `ptr_addr_nxt` are all zero.
- R2: Outputs are registered. A request with `req_valid` high updates every output at the next rising edge and sets `out_valid`. A cycle with `req_valid` low clears `out_valid` and leaves `ea`, `page_cross`, `ptr_need`, `ptr_addr` and `ptr_addr_nxt` unchanged.
- R3: Mode 0 (absolute) gives `ea = {op_hi, op_lo}`. Mode 1 adds X to that value and mode 2 adds Y, both modulo 65536.
- R4: Mode 3 (zero page) gives `{8'h00, op_lo}`. Mode 4 adds X and mode 5 adds Y to `op_lo` modulo 256, and the high byte is always 00.
- R5: Mode 11 (stack) gives `{8'h01, sp}`.
- R6: Mode 6 (X-indexed before pointer) gives `ptr_addr = {00, op_lo + X mod 256}` and `ea = {ptr_hi, ptr_lo}`.
- R7: Mode 7 (Y-indexed after pointer) gives `ptr_addr = {00, op_lo}` and `ea = {ptr_hi, ptr_lo} + Y`.
- R8: Mode 8 (zero-page indirect) gives `ptr_addr = {00, op_lo}` and `ea = {ptr_hi, ptr_lo}`, with no index added.
- R9: Mode 9 (absolute indirect) gives `ptr_addr = {op_hi, op_lo}`. Mode 10 (X-indexed absolute indirect, jumps only) gives `ptr_addr = {op_hi, op_lo} + X`. Both give `ea = {ptr_hi, ptr_lo}`.
- R10: Mode 12 (relative) gives `ea = pc + sign-extended op_lo`.
- R11: `page_cross` is 1 only in modes 1, 2 and 7, and only when the high byte of `ea` differs from the high byte of the base that was indexed.
- R12: `ptr_need` is 1 exactly for modes 6 to 10. `ptr_addr_nxt` is the address of the pointer's high byte: in modes 6 to 8 it is `{00, low byte of ptr_addr + 1 mod 256}`, so a pointer at 00FF continues at 0000. In modes 9 and 10 it is `ptr_addr + 1`. In every mode without a pointer, `ptr_addr` and `ptr_addr_nxt` are 0.
- R13: Mode codes 13 to 15 are unused and give zero on every output except `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Compute request |
| mode | input | 4 | Addressing mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| sp | input | 8 | Stack pointer |
| ptr_lo | input | 8 | Fetched pointer low byte |
| ptr_hi | input | 8 | Fetched pointer high byte |
| pc | input | 16 | Program counter |
| out_valid | output | 1 | Result registered this cycle |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexing changed the page |
| ptr_need | output | 1 | Mode reads a pointer |
| ptr_addr | output | 16 | Pointer low-byte address |
| ptr_addr_nxt | output | 16 | Pointer high-byte address |

## Verification
The properties assume that every input is settled at the rising edge where `req_valid` is high. They also assume that the checked mode codes are held only for that edge, since each property compares the cycle after a request with the request itself. The bench changes inputs only on falling edges and keeps each request to a single cycle. It then drops `req_valid` before it checks that the outputs hold, so no property sees a half-updated request. The pointer bytes are treated as already fetched, so each vector supplies them together with its mode.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] ptr_lo,
  input  logic [DW-1:0] ptr_hi,
  input  logic [AW-1:0] pc,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic          page_cross,
  output logic          ptr_need,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] ptr_addr_nxt
);
  localparam logic [DW-1:0] PG_STACK = DW'(1);

  logic [AW-1:0] abs_base, ptr_val, idx_base, idx_sum, rel_t;
  logic [DW-1:0] idx_amt, zp_x, zp_y;
  logic          use_idx;

  assign abs_base = {op_hi, op_lo};
  assign ptr_val  = {ptr_hi, ptr_lo};
  assign zp_x     = op_lo + idx_x;
  assign zp_y     = op_lo + idx_y;
  assign rel_t    = pc + {{(AW-DW){op_lo[DW-1]}}, op_lo};
  assign idx_base = (mode == 4'd7) ? ptr_val : abs_base;
  assign idx_amt  = (mode == 4'd1) ? idx_x : idx_y;
  assign idx_sum  = idx_base + {{(AW-DW){1'b0}}, idx_amt};
  assign use_idx  = (mode == 4'd1) || (mode == 4'd2) || (mode == 4'd7);

  logic [AW-1:0] ea_d, pa_d, pn_d;
  logic          pc_d, pn_need;

  always_comb begin
    ea_d = '0;
    pa_d = '0;
    pn_d = '0;
    pn_need = 1'b0;
    unique case (mode)
      4'd0:  ea_d = abs_base;
      4'd1,
      4'd2:  ea_d = idx_sum;
      4'd3:  ea_d = {{DW{1'b0}}, op_lo};
      4'd4:  ea_d = {{DW{1'b0}}, zp_x};
      4'd5:  ea_d = {{DW{1'b0}}, zp_y};
      4'd6: begin
        pa_d = {{DW{1'b0}}, zp_x};
        pn_d = {{DW{1'b0}}, zp_x + DW'(1)};
        ea_d = ptr_val;
        pn_need = 1'b1;
      end
      4'd7: begin
        pa_d = {{DW{1'b0}}, op_lo};
        pn_d = {{DW{1'b0}}, op_lo + DW'(1)};
        ea_d = idx_sum;
        pn_need = 1'b1;
      end
      4'd8: begin
        pa_d = {{DW{1'b0}}, op_lo};
        pn_d = {{DW{1'b0}}, op_lo + DW'(1)};
        ea_d = ptr_val;
        pn_need = 1'b1;
      end
      4'd9: begin
        pa_d = abs_base;
        pn_d = abs_base + AW'(1);
        ea_d = ptr_val;
        pn_need = 1'b1;
      end
      4'd10: begin
        pa_d = abs_base + {{(AW-DW){1'b0}}, idx_x};
        pn_d = abs_base + {{(AW-DW){1'b0}}, idx_x} + AW'(1);
        ea_d = ptr_val;
        pn_need = 1'b1;
      end
      4'd11: ea_d = {PG_STACK, sp};
      4'd12: ea_d = rel_t;
      default: ;
    endcase
  end

  assign pc_d = use_idx && (idx_sum[AW-1:DW] != idx_base[AW-1:DW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      ea           <= '0;
      page_cross   <= 1'b0;
      ptr_need     <= 1'b0;
      ptr_addr     <= '0;
      ptr_addr_nxt <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        ea           <= ea_d;
        page_cross   <= pc_d;
        ptr_need     <= pn_need;
        ptr_addr     <= pa_d;
        ptr_addr_nxt <= pn_d;
      end
    end
  end
endmodule

module ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  mode,
  input logic [7:0]  sp,
  input logic        out_valid,
  input logic [15:0] ea,
  input logic        page_cross,
  input logic        ptr_need
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(ea)));
  // R4
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode >= 4'd3 && mode <= 4'd5) |=> (ea[15:8] == 8'h00));
  // R5
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 4'd11) |=> (ea == {8'h01, $past(sp)}));
  // R11
  cross_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode != 4'd1 && mode != 4'd2 && mode != 4'd7) |=> !page_cross);
  // R12
  ptr_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (ptr_need == ($past(mode) >= 4'd6 && $past(mode) <= 4'd10)));
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .sp(sp),
  .out_valid(out_valid), .ea(ea), .page_cross(page_cross), .ptr_need(ptr_need)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0, sp = '0, ptr_lo = '0, ptr_hi = '0;
  logic [15:0] pc = '0;
  logic out_valid, page_cross, ptr_need;
  logic [15:0] ea, ptr_addr, ptr_addr_nxt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ea_gen uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .sp(sp),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .pc(pc), .out_valid(out_valid), .ea(ea),
    .page_cross(page_cross), .ptr_need(ptr_need), .ptr_addr(ptr_addr),
    .ptr_addr_nxt(ptr_addr_nxt));

  typedef struct packed {
    logic [3:0] m; logic [7:0] lo, hi, x, y, s, pl, ph; logic [15:0] p;
    logic [15:0] e; logic c, n; logic [15:0] a, an;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  8'h34,8'h12,8'h00,8'h00,8'h00,8'h00,8'h00,16'h0000, 16'h1234,1'b0,1'b0,16'h0000,16'h0000}, // R3
    '{4'd1,  8'hF0,8'h12,8'h20,8'h00,8'h00,8'h00,8'h00,16'h0000, 16'h1310,1'b1,1'b0,16'h0000,16'h0000}, // R3 R11
    '{4'd1,  8'h10,8'h12,8'h20,8'h00,8'h00,8'h00,8'h00,16'h0000, 16'h1230,1'b0,1'b0,16'h0000,16'h0000}, // R3 R11
    '{4'd2,  8'hFF,8'hFF,8'h00,8'h01,8'h00,8'h00,8'h00,16'h0000, 16'h0000,1'b1,1'b0,16'h0000,16'h0000}, // R3 R11
    '{4'd3,  8'h80,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,16'h0000, 16'h0080,1'b0,1'b0,16'h0000,16'h0000}, // R4
    '{4'd4,  8'hF0,8'h00,8'h20,8'h00,8'h00,8'h00,8'h00,16'h0000, 16'h0010,1'b0,1'b0,16'h0000,16'h0000}, // R4 wrap
    '{4'd5,  8'h05,8'h00,8'h00,8'h03,8'h00,8'h00,8'h00,16'h0000, 16'h0008,1'b0,1'b0,16'h0000,16'h0000}, // R4
    '{4'd6,  8'hFE,8'h00,8'h01,8'h00,8'h00,8'h00,8'h30,16'h0000, 16'h3000,1'b0,1'b1,16'h00FF,16'h0000}, // R6 R12
    '{4'd7,  8'h40,8'h00,8'h00,8'h20,8'h00,8'hF0,8'h20,16'h0000, 16'h2110,1'b1,1'b1,16'h0040,16'h0041}, // R7 R11
    '{4'd7,  8'h40,8'h00,8'h00,8'h20,8'h00,8'h00,8'h20,16'h0000, 16'h2020,1'b0,1'b1,16'h0040,16'h0041}, // R7
    '{4'd8,  8'h50,8'h00,8'h07,8'h09,8'h00,8'h78,8'h56,16'h0000, 16'h5678,1'b0,1'b1,16'h0050,16'h0051}, // R8
    '{4'd9,  8'hFF,8'h02,8'h00,8'h00,8'h00,8'h00,8'h80,16'h0000, 16'h8000,1'b0,1'b1,16'h02FF,16'h0300}, // R9 R12
    '{4'd10, 8'hFE,8'h02,8'h03,8'h00,8'h00,8'hBC,8'h9A,16'h0000, 16'h9ABC,1'b0,1'b1,16'h0301,16'h0302}, // R9
    '{4'd11, 8'h00,8'h00,8'h00,8'h00,8'hFD,8'h00,8'h00,16'h0000, 16'h01FD,1'b0,1'b0,16'h0000,16'h0000}, // R5
    '{4'd12, 8'hFE,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,16'h1000, 16'h0FFE,1'b0,1'b0,16'h0000,16'h0000}, // R10
    '{4'd12, 8'h20,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,16'h10F0, 16'h1110,1'b0,1'b0,16'h0000,16'h0000}, // R10
    '{4'd14, 8'h55,8'h66,8'h01,8'h02,8'h03,8'h04,8'h05,16'h0777, 16'h0000,1'b0,1'b0,16'h0000,16'h0000}  // R13
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; mode = v.m; op_lo = v.lo; op_hi = v.hi; idx_x = v.x; idx_y = v.y;
    sp = v.s; ptr_lo = v.pl; ptr_hi = v.ph; pc = v.p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {out_valid, page_cross, ptr_need, ea, ptr_addr, ptr_addr_nxt}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {out_valid, ea}, '0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk("R2 valid", out_valid, 1'b1);
      chk($sformatf("R3-13 vec%0d ea", i), ea, VEC[i].e);
      chk($sformatf("R11 vec%0d cross", i), page_cross, VEC[i].c);
      chk($sformatf("R12 vec%0d need", i), ptr_need, VEC[i].n);
      chk($sformatf("R12 vec%0d paddr", i), ptr_addr, VEC[i].a);
      chk($sformatf("R12 vec%0d pnxt", i), ptr_addr_nxt, VEC[i].an);
    end

    // R2 hold while idle, with changed inputs
    apply(VEC[7]);
    mode = 4'd0; op_lo = 8'h11; op_hi = 8'h22; ptr_hi = 8'h44;
    @(negedge clk);
    chk("R2 idle", out_valid, 1'b0);
    chk("R2 hold ea", ea, 16'h3000);
    chk("R2 hold ptr", {ptr_need, ptr_addr, ptr_addr_nxt}, {1'b1, 16'h00FF, 16'h0000});

    // R1 reset mid-run
    apply(VEC[1]);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reclear", {out_valid, page_cross, ea}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule